// File: doc/BRIEF.md
# Credit-Gated Multi-Thread Link Arbiter

This block is the sending end of one shared packet link that carries many independent thread streams. The streams share the link by taking turns one data phase at a time. Phases of different threads may interleave on the link. Phases of one thread always leave in the order that thread presents them. Eight forward threads (source to destination) and eight reverse threads (destination to source) each present their next phase: a data word, a phase type code and a valid flag. Each thread also has a 3-bit priority. The block keeps one credit counter per thread, and the far end refills these counters through a credit return port.

In every cycle the arbiter first narrows the field to the threads that hold both a pending phase and at least one credit. Any eligible reverse thread beats every forward thread. Within the winning direction, the highest priority wins. Ties are broken by a rotating pointer. The winning thread gets a one-cycle ready strobe, which pops its phase, and loses one credit. On the next cycle the phase appears on the registered link outputs, tagged with a 16-bit thread ID and its type code.

Top module: `link_thread_arbiter`

## Requirements
- R1: A thread is granted (its ready bit high) only when its valid bit is high and its credit count is nonzero; at most one ready bit across both directions is high in a cycle.
- R2: When any reverse thread is eligible, no forward thread is granted, whatever the priorities.
- R3: Within the winning direction, the granted thread has the largest 3-bit priority among that direction's eligible threads (larger value wins).
- R4: Among eligible threads of equal top priority in one direction, the grant rotates: the search starts at the index after that direction's last granted thread (index 0 first after reset), so 8 equally ranked, always-eligible threads are each granted once in 8 consecutive grants.
- R5: The grant is decided combinationally in cycle t (ready strobe in cycle t); link_valid is high in cycle t+1 exactly when some thread was granted in cycle t.
- R6: link_tid for forward thread i is 16'h0000 + i; for reverse thread i it is 16'h8000 + i, so bit 15 marks a reverse thread.
- R7: link_type and link_data carry the granted thread's type code and data unchanged, and phases of one thread leave in order. Type codes: 0 packet info, 1 direct IO info, 2 timestamp, 3 software info, 4 control, 5 payload, 6 status.
- R8: A thread's credit count drops by one per grant. It rises by cr_amt when cr_valid is high and cr_rev/cr_idx select it (cr_rev=1 means reverse, cr_idx is the thread index). Both changes apply in the same cycle, and the count saturates at 15.
- R9: When no thread is eligible, link_valid is low in the next cycle and, without a credit return, all credit counts stay as they were.
- R10: Reset (synchronous, active high) clears link_valid and all credit counts to zero and sets both rotation pointers so that index 0 is searched first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_valid | input | 8 | Forward thread i has a phase pending |
| fwd_data | input | 256 | Forward thread i data in bits [32i+31:32i] |
| fwd_type | input | 24 | Forward thread i type code in bits [3i+2:3i] |
| fwd_prio | input | 24 | Forward thread i priority in bits [3i+2:3i] |
| fwd_ready | output | 8 | Grant / pop strobe per forward thread |
| rev_valid | input | 8 | Reverse thread i has a phase pending |
| rev_data | input | 256 | Reverse thread i data |
| rev_type | input | 24 | Reverse thread i type code |
| rev_prio | input | 24 | Reverse thread i priority |
| rev_ready | output | 8 | Grant / pop strobe per reverse thread |
| cr_valid | input | 1 | Credit return present this cycle |
| cr_rev | input | 1 | Credit return targets a reverse thread |
| cr_idx | input | 3 | Thread index of the credit return |
| cr_amt | input | 4 | Number of credits returned |
| link_valid | output | 1 | Link phase valid |
| link_tid | output | 16 | Thread ID of the link phase |
| link_type | output | 3 | Type code of the link phase |
| link_data | output | 32 | Data of the link phase |

## Verification
An off-by-one credit count shows up at the ports in the cycle it matters. A thread with a phase pending is granted when it should be idle, or stays idle when it should be granted. The ready strobe in that same cycle gives it away, and link_valid shows it one cycle later. A pointer that rotates wrongly, or a priority compare that is wrong, changes which ready bit rises in the very cycle of the decision. A bad output mux shows up one cycle later as a wrong thread ID, type or data word on the link. The bench models credits, queues and pointers itself and compares the ready strobes and the link outputs in every cycle.

// File: rtl/link_arb_pkg.sv
package link_arb_pkg;

  localparam int TID_W   = 16;
  localparam int PTYPE_W = 3;

  typedef enum logic [PTYPE_W-1:0] {
    PH_PKT_INFO = 3'd0,
    PH_DIO_INFO = 3'd1,
    PH_TSTAMP   = 3'd2,
    PH_SW_INFO  = 3'd3,
    PH_CTRL     = 3'd4,
    PH_PAYLOAD  = 3'd5,
    PH_STATUS   = 3'd6,
    PH_RSVD     = 3'd7
  } phase_type_e;

  // Direction bit on top, base plus index below.
  function automatic logic [TID_W-1:0] make_tid(
    input logic             rev,
    input logic [TID_W-2:0] base,
    input logic [TID_W-2:0] idx
  );
    return {rev, base + idx};
  endfunction

endpackage

// File: rtl/link_credit_ctr.sv
module link_credit_ctr #(
  parameter int CRED_W   = 4,
  parameter int CRED_MAX = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              give,
  input  logic [CRED_W-1:0] amt,
  output logic [CRED_W-1:0] cnt
);

  localparam int SUM_W = CRED_W + 1;

  logic [SUM_W-1:0] sum;

  // take is only raised while cnt is nonzero, so no underflow
  always_comb begin
    sum = {1'b0, cnt};
    if (give) sum = sum + {1'b0, amt};
    if (take) sum = sum - SUM_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)                         cnt <= '0;
    else if (sum > SUM_W'(CRED_MAX)) cnt <= CRED_W'(CRED_MAX);
    else                             cnt <= sum[CRED_W-1:0];
  end

endmodule

// File: rtl/link_dir_pick.sv
module link_dir_pick #(
  parameter  int N      = 8,
  parameter  int PRIO_W = 3,
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        elig,
  input  logic [N*PRIO_W-1:0] prio,
  input  logic                advance,
  output logic                any,
  output logic [N-1:0]        gnt,
  output logic [IDX_W-1:0]    win
);

  logic [PRIO_W-1:0] top_p;
  logic [N-1:0]      cand;
  logic [IDX_W-1:0]  ptr;
  logic              found;
  int                pos;

  // Stage 1: highest priority present among eligible threads
  always_comb begin
    top_p = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (prio[i*PRIO_W +: PRIO_W] > top_p))
        top_p = prio[i*PRIO_W +: PRIO_W];
    end
    for (int i = 0; i < N; i++)
      cand[i] = elig[i] && (prio[i*PRIO_W +: PRIO_W] == top_p);
  end

  // Stage 2: rotate from the slot after the last winner
  always_comb begin
    found = 1'b0;
    win   = '0;
    gnt   = '0;
    pos   = 0;
    for (int k = 1; k <= N; k++) begin
      pos = int'(ptr) + k;
      if (pos >= N) pos = pos - N;
      if (!found && cand[pos]) begin
        found = 1'b1;
        win   = IDX_W'(pos);
      end
    end
    if (found) gnt[win] = 1'b1;
  end

  assign any = found;

  always_ff @(posedge clk) begin
    if (rst)                   ptr <= IDX_W'(N-1);
    else if (advance && found) ptr <= win;
  end

endmodule

// File: rtl/link_thread_arbiter.sv
module link_thread_arbiter
  import link_arb_pkg::*;
#(
  parameter  int          NFWD         = 8,
  parameter  int          NREV         = 8,
  parameter  int          DATA_W       = 32,
  parameter  int          PRIO_W       = 3,
  parameter  int          CRED_W       = 4,
  parameter  int          CRED_MAX     = 15,
  parameter  logic [14:0] FWD_TID_BASE = 15'h0000,
  parameter  logic [14:0] REV_TID_BASE = 15'h0000,
  localparam int          NMAX         = (NFWD > NREV) ? NFWD : NREV,
  localparam int          CIDX_W       = (NMAX > 1) ? $clog2(NMAX) : 1,
  localparam int          FIDX_W       = (NFWD > 1) ? $clog2(NFWD) : 1,
  localparam int          RIDX_W       = (NREV > 1) ? $clog2(NREV) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NFWD-1:0]         fwd_valid,
  input  logic [NFWD*DATA_W-1:0]  fwd_data,
  input  logic [NFWD*PTYPE_W-1:0] fwd_type,
  input  logic [NFWD*PRIO_W-1:0]  fwd_prio,
  output logic [NFWD-1:0]         fwd_ready,
  input  logic [NREV-1:0]         rev_valid,
  input  logic [NREV*DATA_W-1:0]  rev_data,
  input  logic [NREV*PTYPE_W-1:0] rev_type,
  input  logic [NREV*PRIO_W-1:0]  rev_prio,
  output logic [NREV-1:0]         rev_ready,
  input  logic                    cr_valid,
  input  logic                    cr_rev,
  input  logic [CIDX_W-1:0]       cr_idx,
  input  logic [CRED_W-1:0]       cr_amt,
  output logic                    link_valid,
  output logic [TID_W-1:0]        link_tid,
  output logic [PTYPE_W-1:0]      link_type,
  output logic [DATA_W-1:0]       link_data
);

  logic [NFWD*CRED_W-1:0] fwd_cnt;
  logic [NREV*CRED_W-1:0] rev_cnt;
  logic [NFWD-1:0]        fwd_nz, fwd_elig, fwd_give, fwd_gnt;
  logic [NREV-1:0]        rev_nz, rev_elig, rev_give, rev_gnt;
  logic                   fwd_any, rev_any;
  logic [FIDX_W-1:0]      fwd_win;
  logic [RIDX_W-1:0]      rev_win;
  phase_type_e            type_q;

  // Per-thread credit state, forward side
  for (genvar fi = 0; fi < NFWD; fi++) begin : g_fwd
    assign fwd_nz[fi]   = |fwd_cnt[fi*CRED_W +: CRED_W];
    assign fwd_give[fi] = cr_valid && !cr_rev && (cr_idx == CIDX_W'(fi));
    link_credit_ctr #(.CRED_W(CRED_W), .CRED_MAX(CRED_MAX)) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .take (fwd_ready[fi]),
      .give (fwd_give[fi]),
      .amt  (cr_amt),
      .cnt  (fwd_cnt[fi*CRED_W +: CRED_W])
    );
  end

  // Per-thread credit state, reverse side
  for (genvar ri = 0; ri < NREV; ri++) begin : g_rev
    assign rev_nz[ri]   = |rev_cnt[ri*CRED_W +: CRED_W];
    assign rev_give[ri] = cr_valid && cr_rev && (cr_idx == CIDX_W'(ri));
    link_credit_ctr #(.CRED_W(CRED_W), .CRED_MAX(CRED_MAX)) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .take (rev_ready[ri]),
      .give (rev_give[ri]),
      .amt  (cr_amt),
      .cnt  (rev_cnt[ri*CRED_W +: CRED_W])
    );
  end

  assign fwd_elig = fwd_valid & fwd_nz;
  assign rev_elig = rev_valid & rev_nz;

  link_dir_pick #(.N(NFWD), .PRIO_W(PRIO_W)) u_fwd_pick (
    .clk     (clk),
    .rst     (rst),
    .elig    (fwd_elig),
    .prio    (fwd_prio),
    .advance (!rev_any),
    .any     (fwd_any),
    .gnt     (fwd_gnt),
    .win     (fwd_win)
  );

  link_dir_pick #(.N(NREV), .PRIO_W(PRIO_W)) u_rev_pick (
    .clk     (clk),
    .rst     (rst),
    .elig    (rev_elig),
    .prio    (rev_prio),
    .advance (1'b1),
    .any     (rev_any),
    .gnt     (rev_gnt),
    .win     (rev_win)
  );

  // Reverse traffic outranks forward traffic
  assign rev_ready = rev_gnt;
  assign fwd_ready = rev_any ? '0 : fwd_gnt;

  // Registered link phase: decided now, driven next cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      link_valid <= 1'b0;
      link_tid   <= '0;
      type_q     <= PH_PKT_INFO;
      link_data  <= '0;
    end else begin
      link_valid <= rev_any || fwd_any;
      if (rev_any) begin
        link_tid  <= make_tid(1'b1, REV_TID_BASE, 15'(rev_win));
        type_q    <= phase_type_e'(rev_type[int'(rev_win)*PTYPE_W +: PTYPE_W]);
        link_data <= rev_data[int'(rev_win)*DATA_W +: DATA_W];
      end else if (fwd_any) begin
        link_tid  <= make_tid(1'b0, FWD_TID_BASE, 15'(fwd_win));
        type_q    <= phase_type_e'(fwd_type[int'(fwd_win)*PTYPE_W +: PTYPE_W]);
        link_data <= fwd_data[int'(fwd_win)*DATA_W +: DATA_W];
      end
    end
  end

  assign link_type = type_q;

endmodule

// File: rtl/link_thread_arbiter_chk.sv
module link_thread_arbiter_chk #(
  parameter int NFWD   = 8,
  parameter int NREV   = 8,
  parameter int CRED_W = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NFWD-1:0]        fwd_valid,
  input logic [NREV-1:0]        rev_valid,
  input logic [NFWD-1:0]        fwd_ready,
  input logic [NREV-1:0]        rev_ready,
  input logic                   cr_valid,
  input logic                   link_valid,
  input logic                   link_tid_msb,
  input logic [NFWD*CRED_W-1:0] fwd_cnt,
  input logic [NREV*CRED_W-1:0] rev_cnt
);

  logic [NFWD-1:0] f_has;
  logic [NREV-1:0] r_has;
  logic            granted;

  always_comb begin
    for (int i = 0; i < NFWD; i++) f_has[i] = fwd_cnt[i*CRED_W +: CRED_W] != '0;
    for (int i = 0; i < NREV; i++) r_has[i] = rev_cnt[i*CRED_W +: CRED_W] != '0;
  end

  assign granted = |{rev_ready, fwd_ready};

  // R1
  a_r1_grant_needs_data: assert property (@(posedge clk) disable iff (rst)
    ((fwd_ready & ~fwd_valid) == '0) && ((rev_ready & ~rev_valid) == '0));
  a_r1_grant_needs_credit: assert property (@(posedge clk) disable iff (rst)
    ((fwd_ready & ~f_has) == '0) && ((rev_ready & ~r_has) == '0));
  a_r1_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rev_ready, fwd_ready}));

  // R2
  a_r2_rev_blocks_fwd: assert property (@(posedge clk) disable iff (rst)
    (|(rev_valid & r_has)) |-> (fwd_ready == '0));

  // R5
  a_r5_grant_then_valid: assert property (@(posedge clk) disable iff (rst)
    granted |=> link_valid);

  // R9
  a_r9_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !granted |=> !link_valid);
  a_r9_idle_credits_hold: assert property (@(posedge clk) disable iff (rst)
    (!granted && !cr_valid) |=> ($stable(fwd_cnt) && $stable(rev_cnt)));

  // R6
  a_r6_rev_tid_bit: assert property (@(posedge clk) disable iff (rst)
    (|rev_ready) |=> link_tid_msb);
  a_r6_fwd_tid_bit: assert property (@(posedge clk) disable iff (rst)
    (|fwd_ready) |=> !link_tid_msb);

endmodule

bind link_thread_arbiter link_thread_arbiter_chk #(
  .NFWD(NFWD), .NREV(NREV), .CRED_W(CRED_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .fwd_valid    (fwd_valid),
  .rev_valid    (rev_valid),
  .fwd_ready    (fwd_ready),
  .rev_ready    (rev_ready),
  .cr_valid     (cr_valid),
  .link_valid   (link_valid),
  .link_tid_msb (link_tid[15]),
  .fwd_cnt      (fwd_cnt),
  .rev_cnt      (rev_cnt)
);

// File: tb/link_thread_arbiter_test.sv
module link_thread_arbiter_test;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [7:0]   fwd_valid = '0, rev_valid = '0;
  logic [255:0] fwd_data = '0, rev_data = '0;
  logic [23:0]  fwd_type = '0, rev_type = '0;
  logic [23:0]  fwd_prio = '0, rev_prio = '0;
  logic [7:0]   fwd_ready, rev_ready;
  logic         cr_valid = 1'b0, cr_rev = 1'b0;
  logic [2:0]   cr_idx = '0;
  logic [3:0]   cr_amt = '0;
  logic         link_valid;
  logic [15:0]  link_tid;
  logic [2:0]   link_type;
  logic [31:0]  link_data;

  always #10 clk = ~clk;

  link_thread_arbiter uut (
    .clk(clk), .rst(rst),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data), .fwd_type(fwd_type),
    .fwd_prio(fwd_prio), .fwd_ready(fwd_ready),
    .rev_valid(rev_valid), .rev_data(rev_data), .rev_type(rev_type),
    .rev_prio(rev_prio), .rev_ready(rev_ready),
    .cr_valid(cr_valid), .cr_rev(cr_rev), .cr_idx(cr_idx), .cr_amt(cr_amt),
    .link_valid(link_valid), .link_tid(link_tid),
    .link_type(link_type), .link_data(link_data)
  );

  // Behavioural model state
  logic [34:0] fq [N][$];
  logic [34:0] rq [N][$];
  int fcred [N];
  int rcred [N];
  int fpri [N];
  int rpri [N];
  int fptr, rptr;
  bit m_cr_v, m_cr_r;
  int m_cr_i, m_cr_a;
  bit exp_v;
  logic [15:0] exp_tid;
  logic [34:0] exp_pl;
  bit obs_v;
  logic [15:0] obs_tid;
  int errors = 0, checks = 0;
  int serial = 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic push(input bit rev, input int t);
    logic [34:0] e;
    e = {3'($urandom_range(0, 6)), 32'(serial)};
    serial++;
    if (rev) rq[t].push_back(e); else fq[t].push_back(e);
  endtask

  // Rotating priority pick over a direction; returns -1 if none eligible
  function automatic int model_pick(input bit rev);
    int best, w;
    best = -1; w = -1;
    for (int i = 0; i < N; i++) begin
      bit el;
      el = rev ? (rq[i].size() > 0 && rcred[i] > 0) : (fq[i].size() > 0 && fcred[i] > 0);
      if (el && (rev ? rpri[i] : fpri[i]) > best) best = rev ? rpri[i] : fpri[i];
    end
    if (best < 0) return -1;
    for (int k = 1; k <= N; k++) begin
      int j;
      bit el;
      j = ((rev ? rptr : fptr) + k) % N;
      el = rev ? (rq[j].size() > 0 && rcred[j] > 0) : (fq[j].size() > 0 && fcred[j] > 0);
      if (w < 0 && el && (rev ? rpri[j] : fpri[j]) == best) w = j;
    end
    return w;
  endfunction

  task automatic step();
    int rw, fw;
    logic [7:0] ef, er;
    @(negedge clk);
    // registered link outputs from the previous decision
    chk(link_valid === exp_v, "R5/R9 link_valid", 64'(link_valid), 64'(exp_v));
    if (exp_v) begin
      chk(link_tid === exp_tid, "R6 link_tid", 64'(link_tid), 64'(exp_tid));
      chk({link_type, link_data} === exp_pl, "R7 type/data order", 64'({link_type, link_data}), 64'(exp_pl));
    end
    obs_v = link_valid; obs_tid = link_tid;
    // drive this cycle's inputs
    for (int i = 0; i < N; i++) begin
      fwd_valid[i] = fq[i].size() > 0;
      rev_valid[i] = rq[i].size() > 0;
      fwd_data[i*32 +: 32] = fwd_valid[i] ? fq[i][0][31:0] : 32'h0;
      fwd_type[i*3 +: 3]   = fwd_valid[i] ? fq[i][0][34:32] : 3'h0;
      rev_data[i*32 +: 32] = rev_valid[i] ? rq[i][0][31:0] : 32'h0;
      rev_type[i*3 +: 3]   = rev_valid[i] ? rq[i][0][34:32] : 3'h0;
      fwd_prio[i*3 +: 3]   = 3'(fpri[i]);
      rev_prio[i*3 +: 3]   = 3'(rpri[i]);
    end
    cr_valid = m_cr_v; cr_rev = m_cr_r; cr_idx = 3'(m_cr_i); cr_amt = 4'(m_cr_a);
    #1;
    rw = model_pick(1'b1);
    fw = (rw >= 0) ? -1 : model_pick(1'b0);
    ef = '0; er = '0;
    if (rw >= 0) er[rw] = 1'b1;
    if (fw >= 0) ef[fw] = 1'b1;
    chk(fwd_ready === ef, "R1/R2/R3/R4 fwd_ready", 64'(fwd_ready), 64'(ef));
    chk(rev_ready === er, "R1/R3/R4 rev_ready", 64'(rev_ready), 64'(er));
    // advance the model as the clock edge will
    exp_v = (rw >= 0) || (fw >= 0);
    if (rw >= 0) begin
      exp_tid = 16'h8000 + 16'(rw); exp_pl = rq[rw].pop_front();
      rcred[rw]--; rptr = rw;
    end else if (fw >= 0) begin
      exp_tid = 16'(fw); exp_pl = fq[fw].pop_front();
      fcred[fw]--; fptr = fw;
    end
    if (m_cr_v) begin
      if (m_cr_r) rcred[m_cr_i] = (rcred[m_cr_i] + m_cr_a > 15) ? 15 : rcred[m_cr_i] + m_cr_a;
      else        fcred[m_cr_i] = (fcred[m_cr_i] + m_cr_a > 15) ? 15 : fcred[m_cr_i] + m_cr_a;
    end
    @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int sat_cnt, idle_cnt;
    logic [7:0] seen;
    for (int i = 0; i < N; i++) begin
      fcred[i] = 0; rcred[i] = 0; fpri[i] = 0; rpri[i] = 0;
    end
    fptr = N - 1; rptr = N - 1;
    m_cr_v = 0; m_cr_r = 0; m_cr_i = 0; m_cr_a = 0;
    exp_v = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(link_valid === 1'b0, "R10 reset link_valid", 64'(link_valid), 64'd0);
    chk({rev_ready, fwd_ready} === 16'h0, "R10 reset ready", 64'({rev_ready, fwd_ready}), 64'd0);
    rst = 1'b0;

    // R10: data pending but zero credit after reset, nothing moves
    push(1'b0, 2); push(1'b1, 5);
    repeat (3) step();
    fq[2].delete(); rq[5].delete();
    repeat (2) step();

    // R8: two returns of 15 saturate forward thread 1 at 15
    m_cr_v = 1; m_cr_r = 0; m_cr_i = 1; m_cr_a = 15;
    step(); step();
    m_cr_v = 0;
    for (int k = 0; k < 20; k++) push(1'b0, 1);
    sat_cnt = 0;
    repeat (30) begin
      step();
      if (obs_v && obs_tid == 16'h0001) sat_cnt++;
    end
    chk(sat_cnt == 15, "R8 saturated credit grants", 64'(sat_cnt), 64'd15);

    // R9: thread 1 still has data but no credit, link stays idle
    idle_cnt = 0;
    repeat (6) begin
      step();
      if (obs_v) idle_cnt++;
    end
    chk(idle_cnt == 0, "R9 idle without credit", 64'(idle_cnt), 64'd0);

    // R4: eight equal forward threads rotate
    for (int i = 0; i < N; i++) begin
      fpri[i] = 3;
      for (int k = 0; k < 10; k++) push(1'b0, i);
    end
    for (int i = 0; i < N; i++) begin
      m_cr_v = 1; m_cr_r = 0; m_cr_i = i; m_cr_a = 15;
      step();
    end
    m_cr_v = 0;
    step(); step();
    seen = '0;
    for (int g = 0; g < N; g++) begin
      step();
      if (obs_v && !obs_tid[15]) seen[obs_tid[2:0]] = 1'b1;
    end
    chk(seen == 8'hFF, "R4 rotation covers all", 64'(seen), 64'hFF);

    // R2/R3: a low-priority reverse thread against high-priority forward ones
    rpri[6] = 0;
    push(1'b1, 6); push(1'b1, 6);
    m_cr_v = 1; m_cr_r = 1; m_cr_i = 6; m_cr_a = 1;
    step();
    m_cr_v = 0;
    repeat (4) step();

    // Mixed random traffic, credit returns and priority changes
    for (int c = 0; c < 4000; c++) begin
      if (c % 250 == 0)
        for (int i = 0; i < N; i++) begin
          fpri[i] = $urandom_range(0, 7); rpri[i] = $urandom_range(0, 7);
        end
      for (int i = 0; i < N; i++) begin
        if (fq[i].size() < 6 && $urandom_range(0, 5) == 0) push(1'b0, i);
        if (rq[i].size() < 6 && $urandom_range(0, 9) == 0) push(1'b1, i);
      end
      m_cr_v = $urandom_range(0, 1) == 1;
      m_cr_r = $urandom_range(0, 1) == 1;
      m_cr_i = $urandom_range(0, 7);
      m_cr_a = $urandom_range(1, 4);
      step();
    end
    m_cr_v = 0;
    repeat (4) step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule